// File: doc/BRIEF.md
# Scaled SCL Phase Timer

This block paces the clock line of an I2C master from the system clock. A power-of-two prescaler, selected by a 4-bit exponent, turns the system clock into base ticks. Two phase counts then set how many base ticks the SCL line stays driven low and how many it stays released. Each count field holds one less than the number of ticks its phase lasts. One full SCL period is therefore 2^exp × ((high+1) + (low+1)) system clocks.

The block also supplies timing for the bit engine that shares the bus. A one-cycle change strobe marks the start of every low phase, where SDA may be changed. A one-cycle sample strobe marks the middle of every high phase, where SDA may be read. While SCL is released but still sensed low, because a target is holding the clock, the high phase does not advance. When the enable input is low, the line is released and every counter returns to zero.

Top module: `scl_phase_timer`

## Requirements
- R1: One system clock after `en` is first sampled high, `scl_oe` goes to 1 (SCL driven low). It stays there for (lo_cnt+1) × 2^base_exp system clocks.
- R2: Without stretching, the released (high) phase lasts (hi_cnt+1) × 2^base_exp system clocks. After it a new low phase begins, so the period is 2^base_exp × (hi_cnt+lo_cnt+2).
- R3: `base_exp` is an exponent: each count unit lasts 2^base_exp system clocks.
- R4: `change_stb` is a single-cycle pulse on the first cycle of every low phase, which is the cycle in which `scl_oe` becomes 1. The first pulse comes one clock after `en` is sampled high.
- R5: `sample_stb` is a single-cycle pulse on the first system clock of base tick number floor((hi_cnt+1)/2) of the high phase, with ticks counted from 0. It is issued only while SCL is sensed high.
- R6: While `scl_oe` is 0 and `scl_sense` is 0, the high-phase timing is frozen. A stretch of S cycles delays the sample strobe and the next low phase by exactly S cycles.
- R7: One clock after `en` is sampled low, `scl_oe`, `change_stb` and `sample_stb` are all 0. The internal counters are cleared, so a later enable starts a complete low phase.
- R8: A count field value of 0 gives a phase of exactly one base tick.
- R9: A count field with all bits set gives a phase of 2^CNT_W base ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low releases SCL and clears counters |
| base_exp | input | EXP_W | Prescaler exponent, one base tick = 2^base_exp clocks |
| hi_cnt | input | CNT_W | High phase length minus one, in base ticks |
| lo_cnt | input | CNT_W | Low phase length minus one, in base ticks |
| scl_sense | input | 1 | Sensed level of the SCL line |
| scl_oe | output | 1 | 1 drives SCL low, 0 releases it |
| change_stb | output | 1 | Pulse at the start of each low phase |
| sample_stb | output | 1 | Pulse at the middle of each high phase |

## Verification
The bench builds the timer with its defaults, CNT_W = 4 and EXP_W = 4, and drives exponents from 0 to 5. With these values it can reach the full 16-tick phase, the 1-tick phase, and periods as short as two clocks, while every run stays short. A bus model stretches one high phase by a chosen number of cycles. Another run is disabled in the middle of a high phase and then enabled again, which shows that the counters were cleared.

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int CNT_W = 4,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [EXP_W-1:0] base_exp,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic             scl_sense,
  output logic             scl_oe,
  output logic             change_stb,
  output logic             sample_stb
);
  localparam int PRE_W = 1 << EXP_W;

  logic             active, hi;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;

  wire [PRE_W-1:0] pre_max  = (PRE_W'(1) << base_exp) - PRE_W'(1);
  wire             tick_end = (pre == pre_max);
  wire             stall    = hi & ~scl_sense;
  wire [CNT_W-1:0] lim      = hi ? hi_cnt : lo_cnt;
  wire [CNT_W:0]   mid      = ({1'b0, hi_cnt} + (CNT_W+1)'(1)) >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hi     <= 1'b0;
      pre    <= '0;
      cnt    <= '0;
    end else if (!en || !active) begin
      active <= en;
      hi     <= 1'b0;
      pre    <= '0;
      cnt    <= '0;
    end else if (!stall) begin
      if (tick_end) begin
        pre <= '0;
        if (cnt == lim) begin
          cnt <= '0;
          hi  <= ~hi;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  assign scl_oe     = active & ~hi;
  assign change_stb = scl_oe & (pre == '0) & (cnt == '0);
  assign sample_stb = active & hi & ~stall & (pre == '0) & ({1'b0, cnt} == mid);
endmodule

module scl_phase_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_sense,
  input logic scl_oe,
  input logic change_stb,
  input logic sample_stb
);
  // R4
  low_start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> change_stb);
  // R4
  change_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    change_stb |-> scl_oe);
  // R5
  sample_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (!scl_oe && scl_sense));
  // R5
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(change_stb && sample_stb));
  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !change_stb && !sample_stb));
endmodule

bind scl_phase_timer scl_phase_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_sense(scl_sense),
  .scl_oe(scl_oe), .change_stb(change_stb), .sample_stb(sample_stb)
);

// File: tb/scl_phase_timer_bench.sv
module scl_phase_timer_bench;
  logic clk = 0, rst_n = 0, en = 0;
  logic [3:0] base_exp = 0, hi_cnt = 0, lo_cnt = 0;
  logic scl_oe, change_stb, sample_stb, scl_sense, stretch;
  int cyc = 0, t0 = 0, st_start = 0, st_len = 0;
  int n_tests = 0, n_fail = 0;
  bit have_t0 = 0, mon_on = 0, prev_oe = 0;
  int kind_q[$], time_q[$];
  string tag = "";

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign stretch = have_t0 && (st_len > 0) && ((cyc - t0) >= st_start) &&
                   ((cyc - t0) < st_start + st_len);
  assign scl_sense = ~scl_oe & ~stretch;

  scl_phase_timer u_scl_phase_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .base_exp(base_exp), .hi_cnt(hi_cnt),
    .lo_cnt(lo_cnt), .scl_sense(scl_sense), .scl_oe(scl_oe),
    .change_stb(change_stb), .sample_stb(sample_stb));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, tag, act, exp);
    end
  endtask

  // kinds: 0 change strobe, 1 SCL release, 2 sample strobe
  task automatic see(input int kind);
    int k, t;
    if (kind_q.size() == 0) begin
      check(0, "R2 extra event", kind, -1);
      return;
    end
    k = kind_q.pop_front();
    t = time_q.pop_front();
    check(k == kind, kind == 2 ? "R5 event kind" : "R1 event kind", kind, k);
    check((cyc - t0) == t, kind == 2 ? "R5 timing" : (kind == 1 ? "R1 timing" : "R2 timing"),
          cyc - t0, t);
  endtask

  always @(negedge clk) begin
    if (mon_on && !have_t0 && change_stb) begin
      t0 = cyc;
      have_t0 = 1;
    end
    if (mon_on && have_t0) begin
      if (change_stb) see(0);
      if (prev_oe && !scl_oe) see(1);
      if (sample_stb) see(2);
    end
    prev_oe = scl_oe;
  end

  task automatic push(input int k, input int t);
    kind_q.push_back(k);
    time_q.push_back(t);
  endtask

  task automatic run(input string name, input int b, input int h, input int l,
                     input int s, input int n);
    int p, t, r, k0, guard;
    tag = name;
    p = 1 << b;
    base_exp = 4'(b); hi_cnt = 4'(h); lo_cnt = 4'(l);
    st_start = (l + 1) * p; st_len = s;
    t = 0;
    for (int k = 0; k < n; k++) begin
      int sk;
      sk = (k == 0) ? s : 0;
      push(0, t);
      r = t + (l + 1) * p;
      push(1, r);
      push(2, r + sk + ((h + 1) >> 1) * p);
      t = r + sk + (h + 1) * p;
    end
    push(0, t);
    have_t0 = 0;
    @(negedge clk);
    en = 1; k0 = cyc; mon_on = 1;
    guard = 0;
    while (kind_q.size() != 0 && guard < 5000) begin
      @(negedge clk); #1;
      guard++;
    end
    mon_on = 0;
    check(kind_q.size() == 0, "R2 missing events", kind_q.size(), 0);
    kind_q.delete(); time_q.delete();
    // R4 first change strobe one clock after enable sampled
    check(t0 == k0 + 1, "R4 start latency", t0 - k0, 1);
    en = 0; st_len = 0;
    @(negedge clk);
    // R7 released and quiet after disable
    check(!scl_oe && !change_stb && !sample_stb, "R7 disabled outputs",
          {scl_oe, change_stb, sample_stb}, 0);
    @(negedge clk);
    check(!scl_oe && !change_stb && !sample_stb, "R7 stays idle",
          {scl_oe, change_stb, sample_stb}, 0);
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1;
    check(!scl_oe && !change_stb && !sample_stb, "R7 reset state",
          {scl_oe, change_stb, sample_stb}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 minimum fields, R3 exponent 0
    run("R8 min", 0, 0, 0, 0, 3);
    // R1 R2 R3 asymmetric phases
    run("R2 asym", 2, 3, 1, 0, 2);
    // R9 full fields
    run("R9 max", 1, 15, 15, 0, 1);
    // R6 stretched high phase
    run("R6 stretch", 3, 2, 4, 7, 2);
    // R3 larger exponent
    run("R3 exp5", 5, 1, 0, 0, 2);
    // R7 disable inside a high phase, then restart fresh
    tag = "R7 mid";
    base_exp = 1; hi_cnt = 3; lo_cnt = 3;
    @(negedge clk); en = 1;
    repeat (12) @(negedge clk);
    check(!scl_oe, "R7 in high phase before disable", scl_oe, 0);
    en = 0;
    @(negedge clk);
    check(!scl_oe && !sample_stb, "R7 disabled mid high", {scl_oe, sample_stb}, 0);
    run("R7 restart", 1, 3, 3, 0, 2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule